// File: doc/BRIEF.md
# Merging Write-Miss Buffer

This block sits behind a data cache that does not allocate lines on store misses. Each store that misses is handed to the buffer as a 32-bit word with a byte-enable nibble, and the requester goes on at once instead of waiting for the next memory level. The buffer keeps up to four pending 128-bit blocks. A new store whose block address equals a waiting entry is folded into that entry byte by byte and takes no new slot. The oldest entry is offered downstream as a full-block write with a 16-bit byte mask.

Both data paths use valid/ready. On the store side a transfer happens in a cycle where `st_valid` and `st_ready` are both high. `st_ready` is computed from the buffer state and from `st_addr`, because a merge target makes room even when every slot is taken. It never depends on `st_valid` or `dr_ready`. On the drain side the block holds `dr_valid` and the payload steady until `dr_ready` is seen. The downstream side may hold `dr_ready` low for as long as it likes. A plain load-address input and hazard output let the cache hold back a load whose block is still pending.

Top module: `wmb_merge_queue`

## Requirements
- R1: After reset `dr_valid` is 0, `st_ready` is 1 and `ld_hazard` is 0.
- R2: An accepted store writes byte `i` of `st_data` (bits 8i+7..8i), for each `i` with `st_be[i]`=1, into block byte `4k+i`, where `k` = `st_addr[3:2]`. It sets mask bit `4k+i`. The block address is `st_addr[31:4]`, and it leaves on `dr_addr`.
- R3: A store with no merge target takes a new slot at the tail. Its mask holds only its own enabled bytes, and every byte it did not write reads as zero on `dr_data`.
- R4: A store whose block address equals a pending entry other than the head is merged into that entry. The masks are ORed, the enabled bytes are overwritten with the new data, and no slot is used.
- R5: The head entry, which is the one offered on the drain port, is never a merge target. A store to its block takes a new slot.
- R6: Entries leave in arrival order, one per cycle in which `dr_valid` and `dr_ready` are both 1. `dr_valid` is 1 exactly when at least one entry is pending.
- R7: While `dr_valid` is 1 and `dr_ready` is 0, the next cycle still has `dr_valid` at 1 and the same `dr_addr`, `dr_data` and `dr_mask`.
- R8: With four entries pending and no merge target for `st_addr`, `st_ready` is 0 and the store waits. If a merge target exists, `st_ready` is 1 even when all slots are full.
- R9: A store accepted with `st_be` = 0 changes nothing. No entry appears, and no mask or data changes.
- R10: `ld_hazard` is 1 in the same cycle that `ld_addr[31:4]` equals the block address of any pending entry, head included, and 0 otherwise.
- R11: When a drain and a store happen in the same cycle, the head leaves and the store is merged or allocated as the state before that edge dictates. A store merging into the entry just behind the head lands before that entry is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store miss offered |
| st_ready | output | 1 | Store accepted this cycle |
| st_addr | input | 32 | Byte address of the store |
| st_data | input | 32 | Store word |
| st_be | input | 4 | Byte enables of the store word |
| dr_valid | output | 1 | Block write offered downstream |
| dr_ready | input | 1 | Downstream takes the block |
| dr_addr | output | 28 | Block address (byte address bits 31..4) |
| dr_data | output | 128 | Block data |
| dr_mask | output | 16 | Byte-valid mask of the block |
| ld_addr | input | 32 | Address of a load being looked up |
| ld_hazard | output | 1 | Load block is still pending here |

## Verification
A slot whose valid bit or tag is corrupted shows up in two ways. The first is a wrong `ld_hazard` in that same cycle. The second is a wrong or missing block once that slot reaches the head. A merge steered to the wrong slot, or into the locked head, changes the mask or data of the next block that is drained, or breaks payload stability while `dr_ready` is low. An occupancy count that drifts shows up as a `st_ready` that differs from the bench model at the next store to a fresh block. The random phase keeps the block pool to four addresses so that merges, full stalls and same-cycle drain-plus-store cases come up within a few cycles of each other.

// File: rtl/wmb_pkg.sv
package wmb_pkg;
  localparam int WORD_BYTES = 4;
  localparam int BLK_BYTES  = 16;
  localparam int LANES      = BLK_BYTES / WORD_BYTES;
  localparam int OFS_W      = $clog2(BLK_BYTES);
  localparam int WSEL_W     = $clog2(LANES);
  localparam int BLK_W      = BLK_BYTES * 8;
  localparam int WORD_W     = WORD_BYTES * 8;

  typedef logic [BLK_W-1:0]     blk_data_t;
  typedef logic [BLK_BYTES-1:0] blk_mask_t;
endpackage

// File: rtl/wmb_lane_place.sv
module wmb_lane_place
  import wmb_pkg::*;
(
  input  logic [WSEL_W-1:0]     wsel,
  input  logic [WORD_W-1:0]     word,
  input  logic [WORD_BYTES-1:0] be,
  output blk_data_t             blk_data,
  output blk_mask_t             blk_mask
);
  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    for (genvar by = 0; by < WORD_BYTES; by++) begin : g_byte
      localparam int POS = ln * WORD_BYTES + by;
      logic sel;
      assign sel = (wsel == WSEL_W'(ln)) && be[by];
      assign blk_mask[POS] = sel;
      assign blk_data[POS*8 +: 8] = sel ? word[by*8 +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/wmb_tag_match.sv
module wmb_tag_match #(
  parameter int N  = 4,
  parameter int W  = 28,
  parameter int IW = 2
) (
  input  logic [W-1:0]        key,
  input  logic [N-1:0][W-1:0] tags,
  input  logic [N-1:0]        elig,
  output logic                hit,
  output logic [IW-1:0]       idx
);
  logic [N-1:0] eq;

  for (genvar s = 0; s < N; s++) begin : g_cmp
    assign eq[s] = elig[s] && (tags[s] == key);
  end

  assign hit = |eq;

  always_comb begin
    idx = '0;
    for (int s = N - 1; s >= 0; s--) begin
      if (eq[s]) idx = IW'(s);
    end
  end
endmodule

// File: rtl/wmb_slot_array.sv
module wmb_slot_array
  import wmb_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int TAG_W = 28,
  parameter int IW    = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        alloc_en,
  input  logic [IW-1:0]               alloc_idx,
  input  logic                        merge_en,
  input  logic [IW-1:0]               merge_idx,
  input  logic                        free_en,
  input  logic [IW-1:0]               free_idx,
  input  logic [TAG_W-1:0]            wr_tag,
  input  blk_data_t                   wr_data,
  input  blk_mask_t                   wr_mask,
  output logic [DEPTH-1:0]            vld,
  output logic [DEPTH-1:0][TAG_W-1:0] tags,
  output blk_data_t [DEPTH-1:0]       datas,
  output blk_mask_t [DEPTH-1:0]       masks
);
  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic             v_q;
    logic [TAG_W-1:0] t_q;
    blk_data_t        d_q;
    blk_mask_t        m_q;
    logic             hit_alloc, hit_merge, hit_free;

    assign hit_alloc = alloc_en && (alloc_idx == IW'(s));
    assign hit_merge = merge_en && (merge_idx == IW'(s));
    assign hit_free  = free_en  && (free_idx  == IW'(s));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        t_q <= '0;
        d_q <= '0;
        m_q <= '0;
      end else begin
        if (hit_free) v_q <= 1'b0;
        if (hit_alloc) begin
          v_q <= 1'b1;
          t_q <= wr_tag;
          d_q <= wr_data;
          m_q <= wr_mask;
        end else if (hit_merge) begin
          m_q <= m_q | wr_mask;
          for (int b = 0; b < BLK_BYTES; b++) begin
            if (wr_mask[b]) d_q[b*8 +: 8] <= wr_data[b*8 +: 8];
          end
        end
      end
    end

    assign vld[s]   = v_q;
    assign tags[s]  = t_q;
    assign datas[s] = d_q;
    assign masks[s] = m_q;
  end
endmodule

// File: rtl/wmb_merge_queue.sv
module wmb_merge_queue
  import wmb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    st_valid,
  output logic                    st_ready,
  input  logic [ADDR_W-1:0]       st_addr,
  input  logic [31:0]             st_data,
  input  logic [3:0]              st_be,
  output logic                    dr_valid,
  input  logic                    dr_ready,
  output logic [ADDR_W-OFS_W-1:0] dr_addr,
  output logic [BLK_W-1:0]        dr_data,
  output logic [BLK_BYTES-1:0]    dr_mask,
  input  logic [ADDR_W-1:0]       ld_addr,
  output logic                    ld_hazard
);
  localparam int TAG_W = ADDR_W - OFS_W;
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [IW-1:0]    hd, tl;
  logic [CNT_W-1:0] occ;

  logic [TAG_W-1:0] st_tag, ld_tag;
  blk_data_t        pl_data;
  blk_mask_t        pl_mask;

  logic [DEPTH-1:0]            vld;
  logic [DEPTH-1:0][TAG_W-1:0] tags;
  blk_data_t [DEPTH-1:0]       datas;
  blk_mask_t [DEPTH-1:0]       masks;

  logic [DEPTH-1:0] head_sel, merge_elig;
  logic             st_hit, ld_hit;
  logic [IW-1:0]    st_idx, ld_idx;
  logic             full, st_fire, dr_fire, has_bytes, do_merge, do_alloc;
  logic             unused_lsb;

  assign st_tag     = st_addr[ADDR_W-1:OFS_W];
  assign ld_tag     = ld_addr[ADDR_W-1:OFS_W];
  assign unused_lsb = ^{st_addr[OFS_W-WSEL_W-1:0], ld_addr[OFS_W-1:0], ld_idx};

  wmb_lane_place u_place (
    .wsel     (st_addr[OFS_W-1:OFS_W-WSEL_W]),
    .word     (st_data),
    .be       (st_be),
    .blk_data (pl_data),
    .blk_mask (pl_mask)
  );

  for (genvar s = 0; s < DEPTH; s++) begin : g_head
    assign head_sel[s] = (hd == IW'(s));
  end
  assign merge_elig = vld & ~head_sel;

  wmb_tag_match #(.N(DEPTH), .W(TAG_W), .IW(IW)) u_st_match (
    .key  (st_tag),
    .tags (tags),
    .elig (merge_elig),
    .hit  (st_hit),
    .idx  (st_idx)
  );

  wmb_tag_match #(.N(DEPTH), .W(TAG_W), .IW(IW)) u_ld_match (
    .key  (ld_tag),
    .tags (tags),
    .elig (vld),
    .hit  (ld_hit),
    .idx  (ld_idx)
  );

  assign full      = (occ == CNT_W'(DEPTH));
  assign st_ready  = st_hit || !full;
  assign st_fire   = st_valid && st_ready;
  assign has_bytes = |st_be;
  assign do_merge  = st_fire && has_bytes && st_hit;
  assign do_alloc  = st_fire && has_bytes && !st_hit;

  assign dr_valid  = (occ != '0);
  assign dr_fire   = dr_valid && dr_ready;
  assign dr_addr   = tags[hd];
  assign dr_data   = datas[hd];
  assign dr_mask   = masks[hd];
  assign ld_hazard = ld_hit;

  wmb_slot_array #(.DEPTH(DEPTH), .TAG_W(TAG_W), .IW(IW)) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (do_alloc),
    .alloc_idx (tl),
    .merge_en  (do_merge),
    .merge_idx (st_idx),
    .free_en   (dr_fire),
    .free_idx  (hd),
    .wr_tag    (st_tag),
    .wr_data   (pl_data),
    .wr_mask   (pl_mask),
    .vld       (vld),
    .tags      (tags),
    .datas     (datas),
    .masks     (masks)
  );

  function automatic logic [IW-1:0] ptr_inc(input logic [IW-1:0] p);
    return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hd  <= '0;
      tl  <= '0;
      occ <= '0;
    end else begin
      if (dr_fire)  hd <= ptr_inc(hd);
      if (do_alloc) tl <= ptr_inc(tl);
      occ <= occ + CNT_W'(do_alloc) - CNT_W'(dr_fire);
    end
  end
endmodule

// File: rtl/wmb_merge_queue_chk.sv
module wmb_merge_queue_chk #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    st_ready,
  input logic                    dr_valid,
  input logic                    dr_ready,
  input logic [ADDR_W-5:0]       dr_addr,
  input logic [127:0]            dr_data,
  input logic [15:0]             dr_mask,
  input logic [ADDR_W-5:0]       ld_blk,
  input logic                    ld_hazard,
  input logic [$clog2(DEPTH+1)-1:0] occ
);
  // R7: payload held while the drain is back-pressured
  p_drain_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dr_valid && !dr_ready |=> dr_valid && $stable(dr_addr) && $stable(dr_data) && $stable(dr_mask));

  // R8: occupancy stays within the slot count
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= ($clog2(DEPTH+1))'(DEPTH));

  // R8: the store side only stalls when every slot is taken
  p_stall_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !st_ready |-> occ == ($clog2(DEPTH+1))'(DEPTH));

  // R9: empty-enable stores never create an entry, so a drained block has bytes
  p_mask_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dr_valid |-> dr_mask != '0);

  // R10: a load to the head block is flagged
  p_hazard_head_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dr_valid && (ld_blk == dr_addr) |-> ld_hazard);

  // R1/R6: an empty buffer offers nothing, flags nothing and accepts
  p_empty_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    occ == '0 |-> !dr_valid && st_ready && !ld_hazard);
endmodule

bind wmb_merge_queue wmb_merge_queue_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .st_ready  (st_ready),
  .dr_valid  (dr_valid),
  .dr_ready  (dr_ready),
  .dr_addr   (dr_addr),
  .dr_data   (dr_data),
  .dr_mask   (dr_mask),
  .ld_blk    (ld_addr[ADDR_W-1:4]),
  .ld_hazard (ld_hazard),
  .occ       (occ)
);

// File: tb/wmb_merge_queue_tb_top.sv
module wmb_merge_queue_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         st_valid = 1'b0;
  logic         st_ready;
  logic [31:0]  st_addr = '0;
  logic [31:0]  st_data = '0;
  logic [3:0]   st_be = '0;
  logic         dr_valid;
  logic         dr_ready = 1'b0;
  logic [27:0]  dr_addr;
  logic [127:0] dr_data;
  logic [15:0]  dr_mask;
  logic [31:0]  ld_addr = '0;
  logic         ld_hazard;

  int checks = 0;
  int errs = 0;
  bit done = 0;
  string cur_req = "R6";

  logic [27:0]  m_tag [4];
  logic [127:0] m_data [4];
  logic [15:0]  m_mask [4];
  int           m_cnt = 0;

  bit           prev_hold = 0;
  logic [27:0]  p_addr;
  logic [127:0] p_data;
  logic [15:0]  p_mask;

  always #5 clk = ~clk;

  wmb_merge_queue dut_i (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
    .st_data(st_data), .st_be(st_be),
    .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_addr(dr_addr),
    .dr_data(dr_data), .dr_mask(dr_mask),
    .ld_addr(ld_addr), .ld_hazard(ld_hazard)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int find_merge(input logic [27:0] t);
    for (int j = 1; j < m_cnt; j++) if (m_tag[j] == t) return j;
    return -1;
  endfunction

  function automatic bit exp_hazard(input logic [31:0] la);
    for (int j = 0; j < m_cnt; j++) if (m_tag[j] == la[31:4]) return 1;
    return 0;
  endfunction

  task automatic step(input bit sv, input logic [31:0] a, input logic [31:0] d,
                      input logic [3:0] be, input bit rdy, input logic [31:0] la);
    int tgt;
    bit exp_rdy, exp_vld;
    logic [127:0] nd;
    logic [15:0]  nm;
    @(negedge clk);
    st_valid = sv; st_addr = a; st_data = d; st_be = be; dr_ready = rdy; ld_addr = la;
    #1;
    tgt = find_merge(a[31:4]);
    exp_rdy = (tgt >= 0) || (m_cnt < 4);
    exp_vld = (m_cnt > 0);
    chk("R8 st_ready", 128'(st_ready), 128'(exp_rdy));
    chk("R6 dr_valid", 128'(dr_valid), 128'(exp_vld));
    chk("R10 ld_hazard", 128'(ld_hazard), 128'(exp_hazard(la)));
    if (exp_vld) begin
      chk({cur_req, " dr_addr"}, 128'(dr_addr), 128'(m_tag[0]));
      chk({cur_req, " dr_data"}, dr_data, m_data[0]);
      chk({cur_req, " dr_mask"}, 128'(dr_mask), 128'(m_mask[0]));
    end
    if (prev_hold) begin
      chk("R7 hold addr", 128'(dr_addr), 128'(p_addr));
      chk("R7 hold data", dr_data, p_data);
      chk("R7 hold mask", 128'(dr_mask), 128'(p_mask));
    end
    prev_hold = exp_vld && !rdy;
    p_addr = dr_addr; p_data = dr_data; p_mask = dr_mask;
    // placement per R2
    nd = '0; nm = '0;
    for (int i = 0; i < 4; i++)
      if (be[i]) begin
        nd[8*(4*a[3:2]+i) +: 8] = d[8*i +: 8];
        nm[4*a[3:2]+i] = 1'b1;
      end
    if (sv && exp_rdy && be != 0 && tgt >= 0) begin
      m_mask[tgt] = m_mask[tgt] | nm;
      for (int b = 0; b < 16; b++)
        if (nm[b]) m_data[tgt][8*b +: 8] = nd[8*b +: 8];
    end
    if (exp_vld && rdy) begin
      for (int j = 0; j < 3; j++) begin
        m_tag[j] = m_tag[j+1]; m_data[j] = m_data[j+1]; m_mask[j] = m_mask[j+1];
      end
      m_cnt--;
    end
    if (sv && exp_rdy && be != 0 && tgt < 0) begin
      m_tag[m_cnt] = a[31:4]; m_data[m_cnt] = nd; m_mask[m_cnt] = nm;
      m_cnt++;
    end
  endtask

  task automatic drain_all();
    for (int k = 0; k < 8; k++) step(0, 0, 0, 0, 1, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] ra;
    void'($urandom(32'h5eed_0017));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 dr_valid", 128'(dr_valid), 128'(0));
    chk("R1 st_ready", 128'(st_ready), 128'(1));
    chk("R1 ld_hazard", 128'(ld_hazard), 128'(0));

    // R2/R3: first store allocates, lane 2 bytes 0 and 3 only
    cur_req = "R2/R3";
    step(1, 32'h0000_1008, 32'hAABB_CCDD, 4'b1001, 0, 32'h0000_1000);
    // R5: same block as head, must take a new slot
    cur_req = "R5";
    step(1, 32'h0000_1004, 32'h1122_3344, 4'b0011, 0, 32'h0000_100C);
    // R4: merge into the non-head entry
    cur_req = "R4";
    step(1, 32'h0000_1004, 32'h5566_7788, 4'b1110, 0, 0);
    step(1, 32'h0000_2000, 32'h0102_0304, 4'b1111, 0, 32'h0000_2004);
    step(1, 32'h0000_3000, 32'h0A0B_0C0D, 4'b0100, 0, 0);
    // R8: full, fresh block stalls; then a merge is accepted while full
    cur_req = "R8";
    step(1, 32'h0000_4000, 32'hDEAD_BEEF, 4'b1111, 0, 32'h0000_3000);
    step(1, 32'h0000_200C, 32'hCAFE_F00D, 4'b1111, 0, 0);
    // R11: drain head while merging into the entry behind it
    cur_req = "R11";
    step(1, 32'h0000_1000, 32'h7777_8888, 4'b0001, 1, 0);
    drain_all();
    // R9: empty enables change nothing
    cur_req = "R9";
    step(1, 32'h0000_5000, 32'hFFFF_FFFF, 4'b0000, 0, 32'h0000_5000);
    step(0, 0, 0, 0, 0, 32'h0000_5000);
    drain_all();

    // random phase on a small block pool
    cur_req = "R6";
    for (int n = 0; n < 4000; n++) begin
      ra = {24'h000010 + 24'($urandom % 4), 4'h0, 2'($urandom % 4), 2'b00};
      step(($urandom % 10) < 7, ra, $urandom, ($urandom % 8 == 0) ? 4'b0 : 4'($urandom),
           ($urandom % 10) < 4,
           {24'h000010 + 24'($urandom % 5), 8'($urandom)});
    end
    drain_all();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule